// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives the mode controls of an on-chip flash array to carry out one request made of up to four operations over one region: a block erase, a blank check, a program pass and a verify pass. A request names a destination byte offset inside the flash, a source offset in the data store, a byte count, an operation mask and the flash size code. The sequencer checks the request first. It then runs the selected operations in a fixed order and stops at the first one that fails. When it finishes, it returns a completion code and, where it applies, the failing byte address.

Programming reads the source one 32-bit word at a time and writes the words to the flash in pairs (64 bits). It fires one high-voltage pulse for every four pairs (256 bits), plus one last pulse for a partial final group. Erase selects every block that the target range touches. It then makes the interlock write and fires one pulse. The prefetch limit presented to the flash interface is forced to zero while an erase or program sequence is active, and returns to the configured value afterwards.

The flash and source read ports have a latency of one cycle. The block waits for an external done flag after each pulse and samples the good flag at that point.

Top module: `flash_seq`

## Requirements
- R1: The size code selects the number of 128K high blocks: 5 gives 8, 7 gives 12, 11 gives 20. The flash size is 512K plus 128K per high block. Any other code completes with code 2 and makes no flash access.
- R2: If the destination or the byte count is not a multiple of 8, or destination plus count exceeds the flash size, the request completes with code 1 and makes no flash access. Like every check-phase result, it appears on `done` at the second clock edge after the edge that samples `start`.
- R3: If the destination and source ranges touch any common block, the request completes with code 3.
- R4: The block layout is as follows. Low blocks 0..5 are 16K, 16K, 48K, 48K, 64K and 64K, starting at 0. Mid blocks 0..1 are 128K each, starting at 256K. High blocks are 128K each, starting at 512K. A block's select bit is set when the block overlaps the inclusive range [dest, dest+count-1]. The select bits are presented only while erase select is high.
- R5: Erase (mask bit 0) raises erase select and makes one write of 0xFFFFFFFF at the destination. It then raises high voltage until `fl_done`, samples `fl_good` and drops high voltage, and then drops erase select. A low good flag completes with code 4, with the destination as the failing address.
- R6: While an erase or program sequence is active, the prefetch limit output is 0. At every other time it equals `pf_lim_cfg`.
- R7: Program (mask bit 2) raises program select and writes source words to the flash in 64-bit pairs. One pulse follows every fourth pair, and one last pulse commits a partial group of 1 to 3 pairs. The number of pulses is therefore ceil(pairs/4). Program select drops when the pass ends.
- R8: A low good flag after a program pulse drops program select and completes with code 6. The failing address is the byte address of the last pair committed by that pulse.
- R9: Blank check (mask bit 1) reads every word of the range and completes with code 5 at the first word that is not 0xFFFFFFFF, reporting that word's address.
- R10: Verify (mask bit 3) compares every flash word with the source word at the same offset and completes with code 7 at the first mismatch, reporting its address.
- R11: The operations run in the order erase, blank check, program, verify, and the first failure ends the request. An all-zero mask or a zero count completes at once with code 0. Success is code 0. `done` is a one-cycle pulse.
- R12: High voltage is raised only while exactly one of erase select or program select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| op_mask | input | 4 | Operations: [0] erase, [1] blank check, [2] program, [3] verify |
| dest_off | input | AW | Destination byte offset in flash |
| src_off | input | AW | Source byte offset |
| nbytes | input | AW | Byte count |
| size_code | input | 4 | Flash size code |
| pf_lim_cfg | input | PF_W | Configured prefetch limit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| code | output | 3 | Completion code |
| fail_addr | output | AW | Failing byte address |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | AW | Source read byte address |
| src_rd_data | input | 32 | Source data, one cycle after strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_wr | output | 1 | Flash write strobe |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 32 | Flash write data |
| fl_rdata | input | 32 | Flash read data, one cycle after strobe |
| ers_sel | output | 1 | Erase select |
| pgm_sel | output | 1 | Program select |
| hv_en | output | 1 | High-voltage enable |
| pf_lim | output | PF_W | Prefetch limit to flash interface |
| fl_done | input | 1 | Pulse finished |
| fl_good | input | 1 | Pulse succeeded |
| lo_sel | output | 6 | Low block selects |
| mid_sel | output | 2 | Mid block selects |
| hi_sel | output | 20 | High block selects |

## Verification
Check-phase results (size, range, overlap, empty request) are due on `done` exactly at the second edge after the edge that samples `start`. The bench counts negedges from the strobe and requires `done` at count two. Results that depend on the pulse handshake have no fixed latency, because pulse length is set by the bench's done model. For these, the bench waits on the `done` pulse and then compares the code, the failing address, the pulse counts and the model flash contents. Protocol rules (pulse only with one mode selected, zero prefetch during pulses, no block selects outside erase, quiet controls when idle) are sampled on every falling edge.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_RANGE   = 3'd1,
    RC_SIZE    = 3'd2,
    RC_OVERLAP = 3'd3,
    RC_ERASE   = 3'd4,
    RC_BLANK   = 3'd5,
    RC_PROG    = 3'd6,
    RC_VERIFY  = 3'd7
  } rc_e;

  localparam int OP_ERASE  = 0;
  localparam int OP_BLANK  = 1;
  localparam int OP_PROG   = 2;
  localparam int OP_VERIFY = 3;

  localparam int KB       = 1024;
  localparam int BLK_BIG  = 128 * KB;
  localparam int MID_BASE = 256 * KB;
  localparam int HI_BASE  = 512 * KB;

  // low region: two 16K, two 48K, two 64K blocks
  function automatic int lo_size(input int i);
    if (i < 2) return 16 * KB;
    if (i < 4) return 48 * KB;
    return 64 * KB;
  endfunction

  function automatic int lo_base(input int i);
    int b;
    b = 0;
    for (int k = 0; k < i; k++) b += lo_size(k);
    return b;
  endfunction

endpackage

// File: rtl/flash_blkmask.sv
module flash_blkmask
  import flash_seq_pkg::*;
#(
  parameter int AW    = 24,
  parameter int LO_N  = 6,
  parameter int MID_N = 2,
  parameter int HI_N  = 20
) (
  input  logic [AW:0]      first,
  input  logic [AW:0]      last,
  input  logic             valid,
  output logic [LO_N-1:0]  lo,
  output logic [MID_N-1:0] mid,
  output logic [HI_N-1:0]  hi
);

  // inclusive-range overlap per block; bounds are elaboration constants
  for (genvar g = 0; g < LO_N; g++) begin : g_lo
    localparam logic [AW:0] LB = (AW+1)'(lo_base(g));
    localparam logic [AW:0] UB = (AW+1)'(lo_base(g) + lo_size(g) - 1);
    assign lo[g] = valid && !((UB < first) || (LB > last));
  end

  for (genvar g = 0; g < MID_N; g++) begin : g_mid
    localparam logic [AW:0] LB = (AW+1)'(MID_BASE + g * BLK_BIG);
    localparam logic [AW:0] UB = (AW+1)'(MID_BASE + (g + 1) * BLK_BIG - 1);
    assign mid[g] = valid && !((UB < first) || (LB > last));
  end

  for (genvar g = 0; g < HI_N; g++) begin : g_hi
    localparam logic [AW:0] LB = (AW+1)'(HI_BASE + g * BLK_BIG);
    localparam logic [AW:0] UB = (AW+1)'(HI_BASE + (g + 1) * BLK_BIG - 1);
    assign hi[g] = valid && !((UB < first) || (LB > last));
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    op_mask,
  input  logic [AW-1:0] dest_off,
  input  logic [AW-1:0] src_off,
  input  logic [AW-1:0] nbytes,
  input  logic [3:0]    size_code,
  // range endpoints for the mask builders
  output logic [AW:0]   d_first,
  output logic [AW:0]   d_last,
  output logic [AW:0]   s_first,
  output logic [AW:0]   s_last,
  output logic          rng_valid,
  input  logic          overlap,
  // status
  output logic          busy,
  output logic          done,
  output logic [2:0]    code,
  output logic [AW-1:0] fail_addr,
  // data ports
  output logic          src_rd_en,
  output logic [AW-1:0] src_rd_addr,
  input  logic [31:0]   src_rd_data,
  output logic          fl_rd,
  output logic          fl_wr,
  output logic [AW-1:0] fl_addr,
  output logic [31:0]   fl_wdata,
  input  logic [31:0]   fl_rdata,
  // mode controls
  output logic          ers_sel,
  output logic          pgm_sel,
  output logic          hv_en,
  output logic          pf_hold,
  input  logic          fl_done,
  input  logic          fl_good
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_DISP,
    S_E_ILK, S_E_WAIT, S_E_END,
    S_B_RD, S_B_CMP,
    S_P_SRC, S_P_WR, S_P_WAIT,
    S_V_RD, S_V_CMP
  } st_e;

  localparam logic [31:0] ERASED = 32'hFFFF_FFFF;

  st_e           st;
  logic [3:0]    ops;
  logic [AW-1:0] dest_q, src_q, nb_q;
  logic [3:0]    size_q;
  logic [AW:0]   cur;
  logic [1:0]    chunk;
  logic          good_q;
  logic          ers_r, pgm_r, hv_r, pfz_r, done_r;
  logic [2:0]    code_r;
  logic [AW-1:0] fail_r;

  logic [AW:0]   end_w, cur_nx, fsize;
  logic          size_ok, last_w, misalign;

  always_comb begin
    end_w     = {1'b0, dest_q} + {1'b0, nb_q};
    d_first   = {1'b0, dest_q};
    d_last    = end_w - (AW+1)'(1);
    s_first   = {1'b0, src_q};
    s_last    = {1'b0, src_q} + {1'b0, nb_q} - (AW+1)'(1);
    rng_valid = (nb_q != '0);
    cur_nx    = cur + (AW+1)'(4);
    last_w    = (cur_nx == end_w);
    misalign  = (dest_q[2:0] != 3'b000) || (nb_q[2:0] != 3'b000);
    size_ok   = 1'b1;
    case (size_q)
      4'd5:    fsize = (AW+1)'(HI_BASE + 8 * BLK_BIG);
      4'd7:    fsize = (AW+1)'(HI_BASE + 12 * BLK_BIG);
      4'd11:   fsize = (AW+1)'(HI_BASE + 20 * BLK_BIG);
      default: begin
        fsize   = '0;
        size_ok = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ops    <= '0;
      dest_q <= '0;
      src_q  <= '0;
      nb_q   <= '0;
      size_q <= '0;
      cur    <= '0;
      chunk  <= '0;
      good_q <= 1'b0;
      ers_r  <= 1'b0;
      pgm_r  <= 1'b0;
      hv_r   <= 1'b0;
      pfz_r  <= 1'b0;
      done_r <= 1'b0;
      code_r <= RC_OK;
      fail_r <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          dest_q <= dest_off;
          src_q  <= src_off;
          nb_q   <= nbytes;
          size_q <= size_code;
          ops    <= op_mask;
          st     <= S_CHECK;
        end
        S_CHECK: begin
          if (!size_ok) begin
            done_r <= 1'b1; code_r <= RC_SIZE; fail_r <= '0; st <= S_IDLE;
          end else if (misalign || (end_w > fsize)) begin
            done_r <= 1'b1; code_r <= RC_RANGE; fail_r <= '0; st <= S_IDLE;
          end else if ((ops == 4'b0000) || (nb_q == '0)) begin
            done_r <= 1'b1; code_r <= RC_OK; fail_r <= '0; st <= S_IDLE;
          end else if (overlap) begin
            done_r <= 1'b1; code_r <= RC_OVERLAP; fail_r <= '0; st <= S_IDLE;
          end else begin
            st <= S_DISP;
          end
        end
        S_DISP: begin
          cur   <= d_first;
          chunk <= '0;
          if (ops[OP_ERASE]) begin
            ops[OP_ERASE] <= 1'b0;
            ers_r <= 1'b1;
            pfz_r <= 1'b1;
            st    <= S_E_ILK;
          end else if (ops[OP_BLANK]) begin
            ops[OP_BLANK] <= 1'b0;
            st <= S_B_RD;
          end else if (ops[OP_PROG]) begin
            ops[OP_PROG] <= 1'b0;
            pgm_r <= 1'b1;
            pfz_r <= 1'b1;
            st    <= S_P_SRC;
          end else if (ops[OP_VERIFY]) begin
            ops[OP_VERIFY] <= 1'b0;
            st <= S_V_RD;
          end else begin
            done_r <= 1'b1; code_r <= RC_OK; fail_r <= '0; st <= S_IDLE;
          end
        end
        // erase: interlock write, pulse, release
        S_E_ILK: begin
          hv_r <= 1'b1;
          st   <= S_E_WAIT;
        end
        S_E_WAIT: if (fl_done) begin
          hv_r   <= 1'b0;
          good_q <= fl_good;
          st     <= S_E_END;
        end
        S_E_END: begin
          ers_r <= 1'b0;
          pfz_r <= 1'b0;
          if (!good_q) begin
            done_r <= 1'b1; code_r <= RC_ERASE; fail_r <= dest_q; st <= S_IDLE;
          end else begin
            st <= S_DISP;
          end
        end
        // blank check
        S_B_RD: st <= S_B_CMP;
        S_B_CMP: begin
          if (fl_rdata != ERASED) begin
            done_r <= 1'b1; code_r <= RC_BLANK; fail_r <= cur[AW-1:0]; st <= S_IDLE;
          end else if (last_w) begin
            st <= S_DISP;
          end else begin
            cur <= cur_nx;
            st  <= S_B_RD;
          end
        end
        // program: fetch word, write word, pulse per four pairs
        S_P_SRC: st <= S_P_WR;
        S_P_WR: begin
          cur <= cur_nx;
          if (cur[2]) begin
            chunk <= chunk + 2'd1;
            if ((chunk == 2'd3) || last_w) begin
              hv_r <= 1'b1;
              st   <= S_P_WAIT;
            end else begin
              st <= S_P_SRC;
            end
          end else begin
            st <= S_P_SRC;
          end
        end
        S_P_WAIT: if (fl_done) begin
          hv_r <= 1'b0;
          if (!fl_good) begin
            pgm_r  <= 1'b0;
            pfz_r  <= 1'b0;
            done_r <= 1'b1;
            code_r <= RC_PROG;
            fail_r <= cur[AW-1:0] - AW'(8);
            st     <= S_IDLE;
          end else if (cur == end_w) begin
            pgm_r <= 1'b0;
            pfz_r <= 1'b0;
            chunk <= '0;
            st    <= S_DISP;
          end else begin
            st <= S_P_SRC;
          end
        end
        // verify
        S_V_RD: st <= S_V_CMP;
        S_V_CMP: begin
          if (fl_rdata != src_rd_data) begin
            done_r <= 1'b1; code_r <= RC_VERIFY; fail_r <= cur[AW-1:0]; st <= S_IDLE;
          end else if (last_w) begin
            st <= S_DISP;
          end else begin
            cur <= cur_nx;
            st  <= S_V_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = done_r;
  assign code        = code_r;
  assign fail_addr   = fail_r;
  assign ers_sel     = ers_r;
  assign pgm_sel     = pgm_r;
  assign hv_en       = hv_r;
  assign pf_hold     = pfz_r;
  assign fl_rd       = (st == S_B_RD) || (st == S_V_RD);
  assign fl_wr       = (st == S_E_ILK) || (st == S_P_WR);
  assign fl_addr     = cur[AW-1:0];
  assign fl_wdata    = (st == S_E_ILK) ? ERASED : src_rd_data;
  assign src_rd_en   = (st == S_P_SRC) || (st == S_V_RD);
  assign src_rd_addr = src_q + (cur[AW-1:0] - dest_q);

  AST_HV_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    hv_en |-> (ers_sel ^ pgm_sel)); // R12
  AST_HV_DROPS: assert property (@(posedge clk) disable iff (rst)
    (hv_en && fl_done) |=> !hv_en); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done && (code == RC_RANGE || code == RC_SIZE || code == RC_OVERLAP))
      |-> (!ers_sel && !pgm_sel && !hv_en)); // R2
  AST_PGM_FAIL_DROP: assert property (@(posedge clk) disable iff (rst)
    (done && code == RC_PROG) |-> !pgm_sel); // R8
  AST_WRITE_MODE: assert property (@(posedge clk) disable iff (rst)
    fl_wr |-> (ers_sel || pgm_sel)); // R7

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW    = 24,
  parameter int PF_W  = 3,
  parameter int LO_N  = 6,
  parameter int MID_N = 2,
  parameter int HI_N  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       op_mask,
  input  logic [AW-1:0]    dest_off,
  input  logic [AW-1:0]    src_off,
  input  logic [AW-1:0]    nbytes,
  input  logic [3:0]       size_code,
  input  logic [PF_W-1:0]  pf_lim_cfg,
  output logic             busy,
  output logic             done,
  output logic [2:0]       code,
  output logic [AW-1:0]    fail_addr,
  output logic             src_rd_en,
  output logic [AW-1:0]    src_rd_addr,
  input  logic [31:0]      src_rd_data,
  output logic             fl_rd,
  output logic             fl_wr,
  output logic [AW-1:0]    fl_addr,
  output logic [31:0]      fl_wdata,
  input  logic [31:0]      fl_rdata,
  output logic             ers_sel,
  output logic             pgm_sel,
  output logic             hv_en,
  output logic [PF_W-1:0]  pf_lim,
  input  logic             fl_done,
  input  logic             fl_good,
  output logic [LO_N-1:0]  lo_sel,
  output logic [MID_N-1:0] mid_sel,
  output logic [HI_N-1:0]  hi_sel
);

  logic [AW:0]      d_first, d_last, s_first, s_last;
  logic             rng_valid, overlap, pf_hold;
  logic [LO_N-1:0]  d_lo, s_lo;
  logic [MID_N-1:0] d_mid, s_mid;
  logic [HI_N-1:0]  d_hi, s_hi;

  flash_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk, .rst, .start, .op_mask, .dest_off, .src_off, .nbytes, .size_code,
    .d_first, .d_last, .s_first, .s_last, .rng_valid, .overlap,
    .busy, .done, .code, .fail_addr,
    .src_rd_en, .src_rd_addr, .src_rd_data,
    .fl_rd, .fl_wr, .fl_addr, .fl_wdata, .fl_rdata,
    .ers_sel, .pgm_sel, .hv_en, .pf_hold, .fl_done, .fl_good
  );

  flash_blkmask #(.AW(AW), .LO_N(LO_N), .MID_N(MID_N), .HI_N(HI_N)) u_dmask (
    .first(d_first), .last(d_last), .valid(rng_valid),
    .lo(d_lo), .mid(d_mid), .hi(d_hi)
  );

  flash_blkmask #(.AW(AW), .LO_N(LO_N), .MID_N(MID_N), .HI_N(HI_N)) u_smask (
    .first(s_first), .last(s_last), .valid(rng_valid),
    .lo(s_lo), .mid(s_mid), .hi(s_hi)
  );

  assign overlap = (|(d_lo & s_lo)) || (|(d_mid & s_mid)) || (|(d_hi & s_hi));
  assign lo_sel  = ers_sel ? d_lo  : '0;
  assign mid_sel = ers_sel ? d_mid : '0;
  assign hi_sel  = ers_sel ? d_hi  : '0;
  assign pf_lim  = pf_hold ? '0 : pf_lim_cfg;

  AST_PF_QUIET: assert property (@(posedge clk) disable iff (rst)
    hv_en |-> (pf_lim == '0)); // R6
  AST_ERASE_HAS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (ers_sel && hv_en) |-> ((|lo_sel) || (|mid_sel) || (|hi_sel))); // R4

endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3:0]    op_mask = '0;
  logic [AW-1:0] dest_off = '0, src_off = '0, nbytes = '0;
  logic [3:0]    size_code = 4'd5;
  logic [2:0]    pf_lim_cfg = 3'd5;
  logic          busy, done, fl_rd, fl_wr, src_rd_en, ers_sel, pgm_sel, hv_en;
  logic [2:0]    code, pf_lim;
  logic [AW-1:0] fail_addr, src_rd_addr, fl_addr;
  logic [31:0]   src_rd_data = '0, fl_rdata = '0, fl_wdata;
  logic          fl_done = 1'b0, fl_good = 1'b1;
  logic [5:0]    lo_sel;
  logic [1:0]    mid_sel;
  logic [19:0]   hi_sel;

  always #2 clk = ~clk;

  flash_seq u0 (
    .clk, .rst, .start, .op_mask, .dest_off, .src_off, .nbytes, .size_code,
    .pf_lim_cfg, .busy, .done, .code, .fail_addr,
    .src_rd_en, .src_rd_addr, .src_rd_data,
    .fl_rd, .fl_wr, .fl_addr, .fl_wdata, .fl_rdata,
    .ers_sel, .pgm_sel, .hv_en, .pf_lim, .fl_done, .fl_good,
    .lo_sel, .mid_sel, .hi_sel
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // behavioural flash: absent key reads as erased
  int unsigned fmem [int unsigned];
  int unsigned kq [$];
  bit   inject_bad = 1'b0;
  int   hvcnt = 0;
  bit   hv_prev = 1'b0;
  int   n_erase_p = 0, n_prog_p = 0, n_access = 0, n_ilk_bad = 0;
  logic [27:0] sel_seen = '0;

  function automatic int unsigned fread(int unsigned a);
    return fmem.exists(a) ? fmem[a] : 32'hFFFF_FFFF;
  endfunction

  function automatic int unsigned srcpat(int unsigned a);
    return a ^ 32'h5A00_0000;
  endfunction

  // global block index: 0..5 low, 6..7 mid, 8.. high
  function automatic int unsigned blk_base(int idx);
    case (idx)
      0: return 0;
      1: return 16384;
      2: return 32768;
      3: return 81920;
      4: return 131072;
      5: return 196608;
      default: return 262144 + (idx - 6) * 131072;
    endcase
  endfunction

  function automatic int unsigned blk_size(int idx);
    if (idx < 2) return 16384;
    if (idx < 4) return 49152;
    if (idx < 6) return 65536;
    return 131072;
  endfunction

  // check-phase outcome model: -1 means the request proceeds to operations
  function automatic int exp_check(int unsigned d, int unsigned s, int unsigned n,
                                   int unsigned ops, int unsigned sz);
    int unsigned fsz;
    int hb;
    case (sz)
      5: hb = 8;
      7: hb = 12;
      11: hb = 20;
      default: return 2;
    endcase
    fsz = 524288 + hb * 131072;
    if ((d % 8) != 0 || (n % 8) != 0 || d + n > fsz) return 1;
    if (ops == 0 || n == 0) return 0;
    for (int i = 0; i < 28; i++) begin
      int unsigned lo_b, hi_b;
      lo_b = blk_base(i);
      hi_b = lo_b + blk_size(i) - 1;
      if (!(hi_b < d || lo_b > d + n - 1) && !(hi_b < s || lo_b > s + n - 1)) return 3;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (fl_rd) fl_rdata <= fread(fl_addr);
    if (src_rd_en) src_rd_data <= srcpat(src_rd_addr);
    if (fl_rd || fl_wr) n_access = n_access + 1;
    if (fl_wr && pgm_sel) fmem[fl_addr] = fread(fl_addr) & fl_wdata;
    if (fl_wr && ers_sel && fl_wdata != 32'hFFFF_FFFF) n_ilk_bad = n_ilk_bad + 1;
    if (hv_en) begin
      if (!hv_prev) begin
        if (ers_sel) begin
          n_erase_p = n_erase_p + 1;
          sel_seen = {hi_sel, mid_sel, lo_sel};
          if (!inject_bad) begin
            kq.delete();
            foreach (fmem[k]) begin
              for (int i = 0; i < 28; i++)
                if (sel_seen[i] && k >= blk_base(i) && k < blk_base(i) + blk_size(i))
                  kq.push_back(k);
            end
            foreach (kq[i]) fmem.delete(kq[i]);
          end
        end
        if (pgm_sel) n_prog_p = n_prog_p + 1;
      end
      hvcnt = hvcnt + 1;
      fl_done <= (hvcnt >= 4);
      fl_good <= !inject_bad;
    end else begin
      hvcnt = 0;
      fl_done <= 1'b0;
    end
    hv_prev = hv_en;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // protocol rules compared every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (hv_en && !(ers_sel ^ pgm_sel)) chk("R12 hv with one mode", 1, 0);
      if ((ers_sel || pgm_sel) && pf_lim != 3'd0) chk("R6 prefetch held", pf_lim, 0);
      if (!ers_sel && !pgm_sel && pf_lim != pf_lim_cfg) chk("R6 prefetch restored", pf_lim, pf_lim_cfg);
      if (!ers_sel && {hi_sel, mid_sel, lo_sel} != '0) chk("R4 selects outside erase", 1, 0);
      if (!busy && (ers_sel || pgm_sel || hv_en)) chk("R11 idle quiet", 1, 0);
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
    report();
  end

  int cyc;

  task automatic run(input int unsigned d, input int unsigned s, input int unsigned n,
                     input logic [3:0] ops, input logic [3:0] sz);
    @(negedge clk);
    dest_off = d[AW-1:0]; src_off = s[AW-1:0]; nbytes = n[AW-1:0];
    op_mask = ops; size_code = sz;
    n_erase_p = 0; n_prog_p = 0; n_access = 0; n_ilk_bad = 0; sel_seen = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk("R11 completion", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R12 reset hv", hv_en, 0);
    chk("R6 reset prefetch", pf_lim, 5);

    // R1: bad size code, check-phase latency, no access
    run(32'h0, 32'h300000, 8, 4'hF, 4'd6);
    chk("R1 size code", code, 2);
    chk("R1 latency", cyc, 2);
    chk("R1 no access", n_access, 0);

    // R2: misaligned start, misaligned count, beyond size
    run(32'h1004, 32'h300000, 8, 4'hF, 4'd5);
    chk("R2 misaligned dest", code, exp_check(32'h1004, 32'h300000, 8, 15, 5));
    chk("R2 latency", cyc, 2);
    run(32'h1000, 32'h300000, 12, 4'hF, 4'd5);
    chk("R2 odd count", code, 1);
    run(32'h17FFF8, 32'h300000, 16, 4'hF, 4'd5);
    chk("R2 past end", code, exp_check(32'h17FFF8, 32'h300000, 16, 15, 5));
    chk("R2 no access", n_access, 0);

    // R11: empty mask completes with OK in check phase
    run(32'h17FFF8, 32'h300000, 16, 4'h0, 4'd7);
    chk("R11 empty mask", code, 0);
    chk("R11 empty latency", cyc, 2);

    // R3: source and destination in the same block
    run(32'h4000, 32'h5000, 64, 4'hF, 4'd5);
    chk("R3 overlap", code, exp_check(32'h4000, 32'h5000, 64, 15, 5));
    chk("R3 latency", cyc, 2);

    // R4/R5: erase low block 1 only
    fmem[32'h100] = 32'h1234;
    fmem[32'h4010] = 32'h0;
    run(32'h4000, 32'h300000, 256, 4'h1, 4'd5);
    chk("R5 erase ok", code, 0);
    chk("R4 low select", sel_seen, 28'h0000002);
    chk("R5 one pulse", n_erase_p, 1);
    chk("R5 interlock data", n_ilk_bad, 0);
    chk("R5 erased word", fread(32'h4010), 32'hFFFF_FFFF);
    chk("R4 other block kept", fread(32'h100), 32'h1234);

    // R7/R11: full copy of 10 pairs
    fmem[32'h4020] = 32'h0;
    run(32'h4000, 32'h300000, 80, 4'hF, 4'd5);
    chk("R11 full copy", code, 0);
    chk("R7 pulses partial", n_prog_p, 3);
    chk("R5 erase pulses", n_erase_p, 1);
    for (int k = 0; k < 20; k++)
      chk("R7 data", fread(32'h4000 + 4*k), srcpat(32'h300000 + 4*k));
    chk("R7 program select off", pgm_sel, 0);

    // R7: exact multiple of four pairs
    run(32'h8000, 32'h300100, 64, 4'h5, 4'd5);
    chk("R7 exact pulses", n_prog_p, 2);
    chk("R7 exact code", code, 0);
    chk("R7 last word", fread(32'h803C), srcpat(32'h30013C));

    // R9: blank check failure address
    fmem[32'h2000C] = 32'hAAAA;
    run(32'h20000, 32'h300000, 32, 4'h2, 4'd5);
    chk("R9 blank code", code, 5);
    chk("R9 blank addr", fail_addr, 32'h2000C);

    // R8: program pulse fails on first chunk
    inject_bad = 1'b1;
    run(32'h40000, 32'h300000, 64, 4'h4, 4'd5);
    chk("R8 program code", code, 6);
    chk("R8 program addr", fail_addr, 32'h40018);
    chk("R8 select dropped", pgm_sel, 0);
    chk("R8 single pulse", n_prog_p, 1);

    // R5/R11: erase failure stops before program
    run(32'h60000, 32'h300000, 16, 4'h5, 4'd5);
    chk("R5 erase fail code", code, 4);
    chk("R5 erase fail addr", fail_addr, 32'h60000);
    chk("R11 stop after fail", n_prog_p, 0);
    inject_bad = 1'b0;

    // R10: verify mismatch after three good words
    for (int k = 0; k < 3; k++) fmem[32'h80000 + 4*k] = srcpat(32'h300200 + 4*k);
    run(32'h80000, 32'h300200, 32, 4'h8, 4'd5);
    chk("R10 verify code", code, 7);
    chk("R10 verify addr", fail_addr, 32'h8000C);

    // R4: range crossing from low block 5 into mid block 0
    run(32'h3FFF0, 32'h300000, 32, 4'h1, 4'd5);
    chk("R4 span select", sel_seen, 28'h0000060);

    // R1/R4: largest size code reaches the last high block
    run(32'h2E0000, 32'h0, 8, 4'h1, 4'd11);
    chk("R1 large size ok", code, 0);
    chk("R4 top high block", sel_seen, 28'h8000000);

    repeat (4) @(negedge clk);
    report();
  end

endmodule